// File: doc/BRIEF.md
# Flow-Through Burst SRAM Control Path

This block models the synchronous control path of a flow-through burst SRAM that holds a small array of 32-bit words split into four byte lanes. On every rising clock edge it decodes its inputs and takes one of four actions: deselect, start a new cycle, continue the current burst, or stay idle. The inputs it decodes are two address strobes (a processor strobe and a controller strobe), three chip enables, a global write enable, a byte write enable and four per-lane write enables.

The access address, the write data and the write lane mask are held in registers. Read data comes straight out of the array from the registered address, so it is valid in the same cycle. A registered write beat is committed to the array at the edge that closes that beat. Within a four-beat burst, the address steps through either a linear or an interleaved sequence, chosen by a static input.

Top module: `fsram_ctrl`

## Requirements
- R1: When the processor strobe is low and the main enable is active, a cycle starts at `addr_i` as a read beat, with no lanes written. This holds whatever the controller strobe, the global write enable, the byte write enable and the lane enables are doing. If `oe_n` is low, the addressed word appears on `rdata_o` after that edge.
- R2: When the main enable (`ce_main_n`) is high, the processor strobe is ignored. An idle block stays idle and drives nothing.
- R3: The controller strobe is taken only on an edge where the processor strobe is high. On that edge the write enables are sampled to make the first beat's lane mask. If the main enable is inactive on that edge, the strobe is a deselect rather than being blocked.
- R4: A taken strobe starts a cycle only when `ce_hi` is 1 and `ce_lo_n` is 0. Otherwise the taken strobe is a deselect.
- R5: `wr_all_n` low writes all four lanes of the word.
- R6: With `wr_all_n` high and `wr_byte_n` low, lane k (bits 8k+7..8k) is written exactly when `lane_we_n[k]` is 0. If `wr_byte_n` is high, or all lane enables are high, the beat is a read.
- R7: `drive_o` is 1 only under three conditions together: `oe_n` is low, the current beat is a read within an active burst, and no lane enable was sampled low at the last edge. Any lane enable sampled low turns the output off even for a read. When `drive_o` is 0, `rdata_o` is zero.
- R8: On an edge that starts nothing while a burst is active, `adv_n` low moves the address to the next burst location, and `adv_n` high keeps it. This applies to both read and write beats.
- R9: The burst steps only the two low address bits, and the upper bits stay fixed. With `order_lin`=1, the low bits are the start value plus the beat count, modulo 4. With `order_lin`=0, they are the start value XOR the beat count.
- R10: For a read beat, `rdata_o` shows the array word at the registered address in the cycle right after the edge that captured it.
- R11: A write beat's data is held in a register and written into the array at the next edge, whatever command arrives on that edge. A read of that address from then on returns the new data.
- R12: A deselect ends any burst. Afterwards continuation inputs have no effect and nothing is driven until the next cycle start.
- R13: While `rst_n` is low at an edge, the block becomes idle with `drive_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe_n` are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 6 | Start address of a new cycle |
| strb_proc_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_main_n | input | 1 | Main chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Lets the per-lane enables act, active low |
| lane_we_n | input | 4 | Per-lane write enables, active low, bit k for lane k |
| oe_n | input | 1 | Output enable, active low, acts without the clock |
| order_lin | input | 1 | Burst order select: 1 linear, 0 interleaved |
| wdata_i | input | 32 | Write data for the beat being sampled |
| rdata_o | output | 32 | Read data, zero while not driven |
| drive_o | output | 1 | High while the data bus would be driven |

## Verification
The embedded properties check on every cycle that a processor-strobe start yields a read beat, that the main enable blocks the processor strobe, and that the controller strobe is ignored while the processor strobe is low. They also check that a controller strobe with the main enable off ends the burst, that any lane enable sampled low silences the output, and that an advance steps the beat count by one while the upper address bits stay put. What the array actually holds can be shown only by the bench's scenarios: byte-lane merging, the commit edge of a write beat, the exact linear and interleaved address sequences with their wrap, and read-after-write values.

// File: rtl/fsram_pkg.sv
// Shared sizes and the command type for the flow-through burst SRAM control path.
// Assumes a word made of equal byte lanes and a burst of 2**BURST_W beats.
package fsram_pkg;
    localparam int ADDR_W  = 6;
    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int BURST_W = 2;

    // Action chosen for one clock edge.
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_DESEL = 2'd1,
        CMD_START = 2'd2,
        CMD_CONT  = 2'd3
    } cmd_t;
endpackage

// File: rtl/fsram_decode.sv
// Command decoder: turns strobes, chip enables and write enables into one action per edge,
// plus the lane write mask and the lane-low flag of the new beat.
// Assumes all inputs are already stable at the sampling edge.
module fsram_decode
    import fsram_pkg::*;
#(
    parameter int LANES = fsram_pkg::LANES
) (
    input  logic             strb_proc_n,
    input  logic             strb_ctl_n,
    input  logic             ce_main_n,
    input  logic             ce_hi,
    input  logic             ce_lo_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_we_n,
    input  logic             act_i,
    output cmd_t             cmd_o,
    output logic [LANES-1:0] wmask_o,
    output logic             lane_low_o
);
    logic             sec_ok;
    logic             proc_seen;
    logic             ctl_seen;
    logic [LANES-1:0] mask_raw;

    assign sec_ok    = ce_hi & ~ce_lo_n;
    assign proc_seen = ~strb_proc_n & ~ce_main_n;
    assign ctl_seen  = ~strb_ctl_n & strb_proc_n;

    // Lane mask requested by the write enables on this edge.
    always_comb begin
        if (!wr_all_n) begin
            mask_raw = '1;
        end else if (!wr_byte_n) begin
            mask_raw = ~lane_we_n;
        end else begin
            mask_raw = '0;
        end
    end

    // Pick the action; the processor strobe wins and masks write enables.
    always_comb begin
        cmd_o      = CMD_IDLE;
        wmask_o    = '0;
        lane_low_o = 1'b0;
        if (proc_seen) begin
            cmd_o = sec_ok ? CMD_START : CMD_DESEL;
        end else if (ctl_seen) begin
            cmd_o      = (sec_ok && !ce_main_n) ? CMD_START : CMD_DESEL;
            wmask_o    = mask_raw;
            lane_low_o = ~&lane_we_n;
        end else if (act_i) begin
            cmd_o      = CMD_CONT;
            wmask_o    = mask_raw;
            lane_low_o = ~&lane_we_n;
        end
    end
endmodule

// File: rtl/fsram_burst.sv
// Burst address sequencer: holds the start address and a beat count and forms the access
// address in linear or interleaved order over the low BURST_W bits.
// Assumes order_lin stays put for the length of a burst.
module fsram_burst #(
    parameter int ADDR_W  = fsram_pkg::ADDR_W,
    parameter int BURST_W = fsram_pkg::BURST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              step_i,
    input  logic              order_lin,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] low_bits;

    // Capture a new start address or count one more beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            base_q <= addr_i;
            cnt_q  <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Form the low address bits from start value and count.
    always_comb begin
        if (order_lin) begin
            low_bits = base_q[BURST_W-1:0] + cnt_q;
        end else begin
            low_bits = base_q[BURST_W-1:0] ^ cnt_q;
        end
    end

    generate
        if (ADDR_W > BURST_W) begin : g_upper
            assign addr_o = {base_q[ADDR_W-1:BURST_W], low_bits};
        end else begin : g_only_low
            assign addr_o = low_bits[ADDR_W-1:0];
        end
    endgenerate

    // R8
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R9
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (base_q == $past(base_q)));
endmodule

// File: rtl/fsram_array.sv
// Storage array: one memory per byte lane, written at the clock edge under a lane mask
// and read without a clock from the given address.
// Assumes a single address serves both the write and the read port.
module fsram_array #(
    parameter int ADDR_W = fsram_pkg::ADDR_W,
    parameter int LANES  = fsram_pkg::LANES,
    parameter int LANE_W = fsram_pkg::LANE_W
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES-1:0]        we_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);
    localparam int DEPTH = 2 ** ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        // Write this lane when its mask bit is set.
        always_ff @(posedge clk) begin
            if (we_i[g]) begin
                lane_mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = lane_mem[addr_i];
    end
endmodule

// File: rtl/fsram_ctrl.sv
// Top of the flow-through burst SRAM control path: holds the beat registers (active flag,
// lane mask, lane-low flag, write data) and ties the decoder, the burst sequencer and the
// array together. Read data is passed out without a clock; the output enable gates it.
// Assumes the synchronous inputs meet setup at the rising clock edge.
module fsram_ctrl
    import fsram_pkg::*;
#(
    parameter int ADDR_W  = fsram_pkg::ADDR_W,
    parameter int LANES   = fsram_pkg::LANES,
    parameter int LANE_W  = fsram_pkg::LANE_W,
    parameter int BURST_W = fsram_pkg::BURST_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    strb_proc_n,
    input  logic                    strb_ctl_n,
    input  logic                    adv_n,
    input  logic                    ce_main_n,
    input  logic                    ce_hi,
    input  logic                    ce_lo_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    oe_n,
    input  logic                    order_lin,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    drive_o
);
    localparam int DATA_W = LANES * LANE_W;

    cmd_t              cmd;
    logic [LANES-1:0]  wmask_new;
    logic              lane_low_new;
    logic              act_q;
    logic [LANES-1:0]  wmask_q;
    logic              lane_low_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] arr_rdata;

    fsram_decode #(.LANES(LANES)) dec_i (
        .strb_proc_n (strb_proc_n),
        .strb_ctl_n  (strb_ctl_n),
        .ce_main_n   (ce_main_n),
        .ce_hi       (ce_hi),
        .ce_lo_n     (ce_lo_n),
        .wr_all_n    (wr_all_n),
        .wr_byte_n   (wr_byte_n),
        .lane_we_n   (lane_we_n),
        .act_i       (act_q),
        .cmd_o       (cmd),
        .wmask_o     (wmask_new),
        .lane_low_o  (lane_low_new)
    );

    fsram_burst #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (cmd == CMD_START),
        .addr_i    (addr_i),
        .step_i    ((cmd == CMD_CONT) && !adv_n),
        .order_lin (order_lin),
        .addr_o    (cur_addr)
    );

    fsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) mem_i (
        .clk     (clk),
        .addr_i  (cur_addr),
        .we_i    (wmask_q),
        .wdata_i (wdata_q),
        .rdata_o (arr_rdata)
    );

    // Update the beat registers from the decoded action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q      <= 1'b0;
            wmask_q    <= '0;
            lane_low_q <= 1'b0;
            wdata_q    <= '0;
        end else begin
            unique case (cmd)
                CMD_START, CMD_CONT: begin
                    act_q      <= 1'b1;
                    wmask_q    <= wmask_new;
                    lane_low_q <= lane_low_new;
                    wdata_q    <= wdata_i;
                end
                default: begin
                    act_q      <= 1'b0;
                    wmask_q    <= '0;
                    lane_low_q <= 1'b0;
                end
            endcase
        end
    end

    assign drive_o = act_q & ~|wmask_q & ~lane_low_q & ~oe_n;
    assign rdata_o = drive_o ? arr_rdata : '0;

    // R1
    proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_proc_n && !ce_main_n) |=> (wmask_q == '0));

    // R2
    proc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_proc_n && ce_main_n && !act_q) |=> !act_q);

    // R3
    ctl_main_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_ctl_n && strb_proc_n && ce_main_n) |=> (!act_q && !drive_o));

    // R7
    lane_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(!strb_proc_n && !ce_main_n) && !(&lane_we_n)) |=> !drive_o);

    // R12
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_q && strb_proc_n && strb_ctl_n) |=> !act_q);
endmodule

// File: tb/fsram_ctrl_tb_top.sv
module fsram_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  addr_i;
    logic        strb_proc_n, strb_ctl_n, adv_n, ce_main_n, ce_hi, ce_lo_n;
    logic        wr_all_n, wr_byte_n, oe_n, order_lin;
    logic [3:0]  lane_we_n;
    logic [31:0] wdata_i;
    logic [31:0] rdata_o;
    logic        drive_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    fsram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .strb_proc_n(strb_proc_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_we_n(lane_we_n),
        .oe_n(oe_n), .order_lin(order_lin), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .drive_o(drive_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        ps_n, cs_n, adv_n, m_n, hi, lo_n, ga_n, bw_n;
        logic [3:0]  ln;
        logic        oe_n, lin;
        logic [5:0]  a;
        logic [31:0] wd;
        logic        drv;
        logic [31:0] rd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 29;
    // ps_n cs_n adv_n m_n hi lo_n ga_n bw_n lanes oe_n lin addr wdata | drive rdata | req
    localparam vec_t TBL [NV] = '{
        '{1,0,1,0,1,0,0,1,4'hF,0,1,6'd4,32'h11111111, 0,32'h0,        5},  // R5 ctl write start
        '{1,1,0,0,1,0,0,1,4'hF,0,1,6'd0,32'h22222222, 0,32'h0,        8},  // R8 write advance
        '{1,1,0,0,1,0,0,1,4'hF,0,1,6'd0,32'h33333333, 0,32'h0,        8},  // R8
        '{1,1,0,0,1,0,0,1,4'hF,0,1,6'd0,32'h44444444, 0,32'h0,        8},  // R8
        '{1,1,1,0,1,0,1,1,4'hF,0,1,6'd0,32'h0,        1,32'h44444444, 11}, // R11 read after commit
        '{1,0,1,0,1,0,1,1,4'hF,0,1,6'd6,32'h0,        1,32'h33333333, 10}, // R10 ctl read start
        '{1,1,0,0,1,0,1,1,4'hF,0,1,6'd0,32'h0,        1,32'h44444444, 9},  // R9 linear step
        '{1,1,0,0,1,0,1,1,4'hF,0,1,6'd0,32'h0,        1,32'h11111111, 9},  // R9 linear wrap
        '{0,0,1,0,1,0,0,0,4'h0,0,1,6'd5,32'h0,        1,32'h22222222, 1},  // R1 proc start is read
        '{1,1,1,0,1,0,1,1,4'hF,1,1,6'd0,32'h0,        0,32'h0,        7},  // R7 oe_n high
        '{1,1,1,0,1,0,1,1,4'hE,0,1,6'd0,32'hFFFFFFFF, 0,32'h0,        7},  // R7 lane low mutes
        '{1,1,1,0,1,0,1,1,4'hF,0,1,6'd0,32'h0,        1,32'h22222222, 6},  // R6 no write without wr_byte_n
        '{0,1,1,0,1,0,1,1,4'hF,0,0,6'd5,32'h0,        1,32'h22222222, 9},  // R9 interleaved start
        '{1,1,0,0,1,0,1,1,4'hF,0,0,6'd0,32'h0,        1,32'h11111111, 9},  // R9
        '{1,1,0,0,1,0,1,1,4'hF,0,0,6'd0,32'h0,        1,32'h44444444, 9},  // R9
        '{1,1,0,0,1,0,1,1,4'hF,0,0,6'd0,32'h0,        1,32'h33333333, 9},  // R9
        '{1,1,1,0,1,0,1,0,4'hA,0,0,6'd0,32'hAAAAAAAA, 0,32'h0,        6},  // R6 lanes 0 and 2
        '{1,1,1,0,1,0,1,1,4'hF,0,0,6'd0,32'h0,        1,32'h33AA33AA, 6},  // R6 merged word
        '{1,0,1,0,0,0,1,1,4'hF,0,1,6'd7,32'h0,        0,32'h0,        4},  // R4 ce_hi low deselect
        '{1,1,0,0,1,0,1,1,4'hF,0,1,6'd0,32'h0,        0,32'h0,        12}, // R12 advance while idle
        '{0,1,1,1,1,0,1,1,4'hF,0,1,6'd7,32'h0,        0,32'h0,        2},  // R2 proc blocked
        '{0,0,1,1,1,0,1,1,4'hF,0,1,6'd7,32'h0,        0,32'h0,        3},  // R3 ctl needs proc high
        '{1,0,1,0,1,0,1,1,4'hF,0,1,6'd4,32'h0,        1,32'h11111111, 3},  // R3 ctl read
        '{1,0,1,1,1,0,1,1,4'hF,0,1,6'd5,32'h0,        0,32'h0,        3},  // R3 ctl, main off: deselect
        '{1,1,1,0,1,0,1,1,4'hF,0,1,6'd0,32'h0,        0,32'h0,        12}, // R12 burst ended
        '{1,0,1,0,1,0,1,1,4'hF,0,1,6'd7,32'h0,        1,32'h44444444, 10}, // R10
        '{0,1,1,0,1,1,1,1,4'hF,0,1,6'd6,32'h0,        0,32'h0,        4},  // R4 ce_lo_n high deselect
        '{1,0,1,0,1,0,1,0,4'h7,0,1,6'd4,32'hDEADBEEF, 0,32'h0,        6},  // R6 lane 3 only
        '{1,1,1,0,1,0,1,1,4'hF,0,1,6'd0,32'h0,        1,32'hDE111111, 11}  // R11
    };

    task automatic idle_inputs();
        strb_proc_n = 1; strb_ctl_n = 1; adv_n = 1; ce_main_n = 0; ce_hi = 1; ce_lo_n = 0;
        wr_all_n = 1; wr_byte_n = 1; lane_we_n = 4'hF; oe_n = 0; order_lin = 1;
        addr_i = '0; wdata_i = '0;
    endtask

    task automatic apply(input vec_t v);
        strb_proc_n = v.ps_n; strb_ctl_n = v.cs_n; adv_n = v.adv_n; ce_main_n = v.m_n;
        ce_hi = v.hi; ce_lo_n = v.lo_n; wr_all_n = v.ga_n; wr_byte_n = v.bw_n;
        lane_we_n = v.ln; oe_n = v.oe_n; order_lin = v.lin; addr_i = v.a; wdata_i = v.wd;
    endtask

    task automatic check(input string req, input logic exp_drv, input logic [31:0] exp_rd);
        total++;
        if (drive_o !== exp_drv || rdata_o !== exp_rd) begin
            bad++;
            $display("FAIL %s: drive=%0b rdata=%08h expected drive=%0b rdata=%08h",
                     req, drive_o, rdata_o, exp_drv, exp_rd);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                bad++;
                $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) tick();
        check("R13 reset state", 1'b0, 32'h0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            tick();
            check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].drv, TBL[i].rd);
        end

        // R11: a write beat commits even when the next edge is a deselect.
        idle_inputs();
        strb_ctl_n = 0; addr_i = 6'd9; wr_all_n = 0; wdata_i = 32'h0BADF00D;
        tick();
        check("R11 write beat", 1'b0, 32'h0);
        idle_inputs();
        strb_ctl_n = 0; ce_hi = 0;
        tick();
        check("R11 deselect after write", 1'b0, 32'h0);
        idle_inputs();
        strb_ctl_n = 0; addr_i = 6'd9;
        tick();
        check("R11 data committed", 1'b1, 32'h0BADF00D);

        // R13: reset in the middle of a burst clears it.
        idle_inputs();
        rst_n = 0;
        tick();
        check("R13 reset mid burst", 1'b0, 32'h0);
        rst_n = 1;
        adv_n = 0;
        tick();
        check("R13 idle after reset", 1'b0, 32'h0);

        // R7: oe_n acts without a clock edge.
        idle_inputs();
        strb_proc_n = 0; addr_i = 6'd9;
        tick();
        idle_inputs();
        check("R7 driven with oe_n low", 1'b1, 32'h0BADF00D);
        oe_n = 1;
        #1;
        check("R7 oe_n high mid cycle", 1'b0, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule